// File: doc/BRIEF.md
# I2C Slave Byte Engine with Address Recognition

This block is the slave side of a two-wire serial bus that moves one byte at a time. It oversamples the clock and data lines in the system clock domain and detects START and STOP conditions. It shifts bits in or out on the rising edge of the bus clock. After each byte it raises an interrupt, and it keeps the bus clock held low until software has serviced the byte. An 8-bit control register sets the number of bits in the next byte, the enable, the free-data mode, the 7-bit or 8-bit address comparison, and which of two pin pairs the internal clock and data lines use.

Software programs the control and own-address registers through a small write port. For each transfer it writes the data shift register. That write clears the pending flag and releases the stretched clock. In receive mode the write is a dummy. In transmit mode it supplies the outgoing byte. The first byte after START is checked against the own address unless free-data mode is selected. The result of that check decides whether the engine acknowledges and takes part in the rest of the frame.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, pending reads 1, busy, collision, addressed and general-call read 0, no pad is pulled low and no interrupt has been raised.
- R2: While enable (control bit 3) is 0, no pad is pulled low, pending is forced to 1, busy and collision are forced to 0, and writes to the data shift register leave it unchanged.
- R3: SDA falling while SCL is high (START) sets busy. SDA rising while SCL is high (STOP) clears busy.
- R4: A START forces the bit-count field (control bits 2:0) to 000, so the first byte after START is always 8 bits long, whatever count was programmed.
- R5: A bit count of 1 to 7 makes a data byte that many bits long, and 000 means 8. On the rising SCL edge of the last bit, irq pulses for one clock and pending is set. The received bits end up in the low bits of the shift register, first bit most significant.
- R6: With address recognition on (control bit 4 = 0) and the 7-bit format (control bit 5 = 0), a first byte whose bits 7:1 equal own-address bits 7:1 sets addressed and is acknowledged by pulling SDA low during the ninth clock.
- R7: With control bit 5 = 1, all 8 bits of the first byte must equal the own-address register for a match.
- R8: A first byte of 0x00 with address recognition on is a general call. It sets the general-call flag, is acknowledged and raises irq.
- R9: A first byte that matches neither the own address nor the general call is not acknowledged and raises no irq. Every later byte is ignored until the next START or STOP.
- R10: With control bit 4 = 1 (free-data format), the first byte after START is received as data without comparison, acknowledged, and raises irq. Addressed stays 0.
- R11: After the acknowledge clock, SCL is held low while pending is 1. A write to the data shift register (write address 2) clears pending and releases SCL.
- R12: After a 7-bit match with bit 0 of the first byte = 1, the engine transmits each written byte on SDA, most significant bit first, and changes its SDA drive only while SCL is low.
- R13: Control bit 6 routes SCL to pin pair index 1 when set and index 0 when clear. Control bit 7 does the same for SDA. Unselected pins are never pulled low and their inputs are ignored.
- R14: While transmitting, if a released (1) bit is read back as 0 on the rising SCL edge, the collision flag is set and the engine stops driving SDA until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 own address, 2 data shift |
| reg_wdata | input | 8 | Register write data |
| scl_pad_in | input | 2 | Sensed level of the two SCL pins |
| sda_pad_in | input | 2 | Sensed level of the two SDA pins |
| scl_pad_oe | output | 2 | Pull-low enable for each SCL pin (open drain) |
| sda_pad_oe | output | 2 | Pull-low enable for each SDA pin (open drain) |
| shift_q | output | 8 | Data shift register contents |
| stat_pending | output | 1 | Byte awaiting service |
| stat_busy | output | 1 | Bus between START and STOP |
| stat_collide | output | 1 | Transmitted 1 read back as 0 |
| stat_addressed | output | 1 | Own address matched in this frame |
| stat_gencall | output | 1 | General call received in this frame |
| irq | output | 1 | One-clock pulse when a byte completes |

## Verification
Random bit counts and random data bytes exercise the byte length. The interrupt is checked to stay quiet one bit before the programmed count and to fire on the count itself, which separates the 1 to 7 encodings from the 000-means-8 case. Address bytes are chosen in pairs that differ only in the least significant bit, so one pair separates 7-bit from full-byte comparison. A zero byte, a foreign address and free-data mode each follow a different accept path. Transmit runs check the returned bytes, watch that the SDA drive never moves while SCL is high, and force a readback conflict. Swapping the pin pairs, and a decoy START on the unselected pins, show the routing.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_OWN  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  typedef struct packed {
    logic       sda_sel;
    logic       scl_sel;
    logic       wide;
    logic       free;
    logic       en;
    logic [2:0] bc;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_LAST, S_ACK, S_ACKH, S_SKIP
  } bstate_t;

  // Length of a byte from the count field: zero stands for a full byte.
  function automatic logic [3:0] bits_in_byte(input logic [2:0] bc);
    return (bc == 3'd0) ? 4'd8 : {1'b0, bc};
  endfunction

  // Address comparison: 7-bit form ignores bit 0, wide form compares all bits.
  function automatic logic addr_hit(input logic [7:0] rx, input logic [7:0] own,
                                    input logic wide);
    return wide ? (rx == own) : (rx[7:1] == own[7:1]);
  endfunction

endpackage

// File: rtl/i2cbe_line_sync.sv
module i2cbe_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], raw};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cbe_port_route.sv
module i2cbe_port_route #(
  parameter  int NPORT = 2,
  localparam int SW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [NPORT-1:0] pad_in,
  input  logic [SW-1:0]    sel,
  input  logic             drive,
  output logic             line_in,
  output logic [NPORT-1:0] pad_oe
);
  assign line_in = pad_in[sel];

  for (genvar g = 0; g < NPORT; g++) begin : g_pin
    assign pad_oe[g] = drive && (sel == SW'(g));
  end
endmodule

// File: rtl/i2cbe_byte_ctrl.sv
module i2cbe_byte_ctrl
  import i2cbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  output ctrl_t      ctrl_q,
  output logic       sda_drive,
  output logic       scl_hold,
  output logic [7:0] shift_q,
  output logic       pending,
  output logic       busy,
  output logic       collide,
  output logic       addressed,
  output logic       gencall,
  output logic       irq,
  output logic       start_ev,
  output logic       stop_ev,
  output logic       data_wr
);
  bstate_t    state;
  logic [7:0] own_q;
  logic [3:0] cnt;
  logic       txmode, was_addr, sda_drv, stretch;
  logic [7:0] nb;
  logic [3:0] cnt_n;

  assign start_ev  = scl_lvl & sda_fall;
  assign stop_ev   = scl_lvl & sda_rise;
  assign data_wr   = reg_we && (reg_addr == REG_DATA) && ctrl_q.en;
  assign nb        = {shift_q[6:0], sda_lvl};
  assign cnt_n     = cnt + 4'd1;
  assign sda_drive = ctrl_q.en & sda_drv;
  assign scl_hold  = ctrl_q.en & stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      own_q     <= '0;
      shift_q   <= '0;
      cnt       <= '0;
      state     <= S_IDLE;
      pending   <= 1'b1;
      busy      <= 1'b0;
      collide   <= 1'b0;
      addressed <= 1'b0;
      gencall   <= 1'b0;
      txmode    <= 1'b0;
      was_addr  <= 1'b0;
      sda_drv   <= 1'b0;
      stretch   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reg_we && reg_addr == REG_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
      if (reg_we && reg_addr == REG_OWN)  own_q  <= reg_wdata;
      if (!ctrl_q.en) begin
        pending <= 1'b1;
        busy    <= 1'b0;
        collide <= 1'b0;
        state   <= S_IDLE;
        sda_drv <= 1'b0;
        stretch <= 1'b0;
        txmode  <= 1'b0;
      end else begin
        if (data_wr) begin
          shift_q <= reg_wdata;
          pending <= 1'b0;
          stretch <= 1'b0;
          if (txmode && state == S_DATA && !scl_lvl) sda_drv <= ~reg_wdata[7];
        end
        if (start_ev) begin
          busy      <= 1'b1;
          ctrl_q.bc <= 3'd0;
          cnt       <= '0;
          state     <= ctrl_q.free ? S_DATA : S_ADDR;
          addressed <= 1'b0;
          gencall   <= 1'b0;
          txmode    <= 1'b0;
          sda_drv   <= 1'b0;
          stretch   <= 1'b0;
        end else if (stop_ev) begin
          busy    <= 1'b0;
          state   <= S_IDLE;
          txmode  <= 1'b0;
          sda_drv <= 1'b0;
          stretch <= 1'b0;
        end else if (scl_rise) begin
          case (state)
            S_ADDR, S_DATA: begin
              if (txmode && state == S_DATA && shift_q[7] && !sda_lvl) begin
                collide <= 1'b1;
                state   <= S_SKIP;
                sda_drv <= 1'b0;
              end else begin
                shift_q <= nb;
                cnt     <= cnt_n;
                if (cnt_n == bits_in_byte(ctrl_q.bc)) begin
                  was_addr <= (state == S_ADDR);
                  if (state == S_DATA) begin
                    pending <= 1'b1;
                    irq     <= 1'b1;
                    state   <= S_LAST;
                  end else if (nb == 8'h00) begin
                    gencall <= 1'b1;
                    pending <= 1'b1;
                    irq     <= 1'b1;
                    state   <= S_LAST;
                  end else if (addr_hit(nb, own_q, ctrl_q.wide)) begin
                    addressed <= 1'b1;
                    txmode    <= ~ctrl_q.wide & nb[0];
                    pending   <= 1'b1;
                    irq       <= 1'b1;
                    state     <= S_LAST;
                  end else begin
                    state <= S_SKIP;
                  end
                end
              end
            end
            S_ACK:   state <= S_ACKH;
            default: ;
          endcase
        end else if (scl_fall) begin
          case (state)
            S_LAST: begin
              sda_drv <= ~(txmode & ~was_addr);
              state   <= S_ACK;
            end
            S_ACKH: begin
              state   <= S_DATA;
              cnt     <= '0;
              sda_drv <= txmode & ~pending & ~shift_q[7];
              stretch <= pending;
            end
            S_DATA:  if (txmode) sda_drv <= ~shift_q[7];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cbe_pkg::*;
#(
  parameter  int SYNC_STAGES = 2,
  parameter  int NPORT       = 2,
  parameter  int DW          = 8,
  localparam int SW          = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [NPORT-1:0] scl_pad_in,
  input  logic [NPORT-1:0] sda_pad_in,
  output logic [NPORT-1:0] scl_pad_oe,
  output logic [NPORT-1:0] sda_pad_oe,
  output logic [DW-1:0]    shift_q,
  output logic             stat_pending,
  output logic             stat_busy,
  output logic             stat_collide,
  output logic             stat_addressed,
  output logic             stat_gencall,
  output logic             irq
);
  ctrl_t ctrl_q;
  logic  scl_raw, sda_raw;
  logic  scl_lvl, scl_rise, scl_fall;
  logic  sda_lvl, sda_rise, sda_fall;
  logic  sda_drive, scl_hold;
  logic  start_ev, stop_ev, data_wr;
  logic  en, scl_sel, sda_sel;

  assign en      = ctrl_q.en;
  assign scl_sel = ctrl_q.scl_sel;
  assign sda_sel = ctrl_q.sda_sel;

  i2cbe_port_route #(.NPORT(NPORT)) u_scl_route (
    .pad_in(scl_pad_in), .sel(SW'(scl_sel)), .drive(scl_hold),
    .line_in(scl_raw), .pad_oe(scl_pad_oe));

  i2cbe_port_route #(.NPORT(NPORT)) u_sda_route (
    .pad_in(sda_pad_in), .sel(SW'(sda_sel)), .drive(sda_drive),
    .line_in(sda_raw), .pad_oe(sda_pad_oe));

  i2cbe_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .raw(scl_raw),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  i2cbe_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .raw(sda_raw),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  i2cbe_byte_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .ctrl_q(ctrl_q), .sda_drive(sda_drive), .scl_hold(scl_hold),
    .shift_q(shift_q), .pending(stat_pending), .busy(stat_busy),
    .collide(stat_collide), .addressed(stat_addressed), .gencall(stat_gencall),
    .irq(irq), .start_ev(start_ev), .stop_ev(stop_ev), .data_wr(data_wr));
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_sel,
  input logic       sda_sel,
  input logic [1:0] scl_pad_oe,
  input logic [1:0] sda_pad_oe,
  input logic       scl_lvl,
  input logic       sda_drive,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       data_wr,
  input logic       stat_pending,
  input logic       stat_busy,
  input logic       irq
);
  // R13
  unselected_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_sel ? scl_pad_oe[0] : scl_pad_oe[1]) && !(sda_sel ? sda_pad_oe[0] : sda_pad_oe[1]));

  // R2
  disabled_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (scl_pad_oe == 2'b00) && (sda_pad_oe == 2'b00) && stat_pending && !stat_busy);

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_ev) |=> stat_busy);

  // R3
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_ev && !start_ev) |=> !stat_busy);

  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_pending ##1 !irq);

  // R11
  write_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !irq) |=> !stat_pending);

  // R12
  sda_steady_while_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && en && $past(en) && !start_ev && !stop_ev) |-> $stable(sda_drive));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_sel(scl_sel), .sda_sel(sda_sel),
  .scl_pad_oe(scl_pad_oe), .sda_pad_oe(sda_pad_oe), .scl_lvl(scl_lvl),
  .sda_drive(sda_drive), .start_ev(start_ev), .stop_ev(stop_ev),
  .data_wr(data_wr), .stat_pending(stat_pending), .stat_busy(stat_busy),
  .irq(irq));

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;
  localparam int PH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] mscl = 2'b11, msda = 2'b11;
  wire  [1:0] scl_ln, sda_ln;
  logic [1:0] scl_pad_oe, sda_pad_oe;
  logic [7:0] shift_q;
  logic stat_pending, stat_busy, stat_collide, stat_addressed, stat_gencall, irq;

  int checks = 0, fails = 0, irq_cnt = 0, glitch = 0;
  int pc = 0, pd = 0;
  logic prev_hi = 1'b0;
  logic [1:0] prev_oe = '0;

  always #2 clk = ~clk;

  assign scl_ln = mscl & ~scl_pad_oe;
  assign sda_ln = msda & ~sda_pad_oe;

  i2c_byte_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_pad_in(scl_ln), .sda_pad_in(sda_ln),
    .scl_pad_oe(scl_pad_oe), .sda_pad_oe(sda_pad_oe), .shift_q(shift_q),
    .stat_pending(stat_pending), .stat_busy(stat_busy),
    .stat_collide(stat_collide), .stat_addressed(stat_addressed),
    .stat_gencall(stat_gencall), .irq(irq));

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (scl_ln[pc] && prev_hi && sda_pad_oe != prev_oe) glitch++;
    prev_hi = scl_ln[pc];
    prev_oe = sda_pad_oe;
  end

  function automatic int exp_bits(input logic [2:0] bc);
    return (bc == 3'd0) ? 8 : int'(bc);
  endfunction

  // Acknowledge expected for a first byte (0 = pulled low).
  function automatic logic exp_ack(input logic [7:0] b, input logic [7:0] own,
                                   input logic wide, input logic free);
    logic ok;
    if (free || b == 8'h00) ok = 1'b1;
    else if (wide) ok = (b == own);
    else ok = (b[7:1] == own[7:1]);
    return ~ok;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    wait_c(2);
  endtask

  task automatic scl_up();
    mscl[pc] = 1'b1;
    for (int k = 0; k < 2000 && !scl_ln[pc]; k++) @(negedge clk);
    wait_c(PH);
  endtask

  task automatic bit_clk(input logic b, output logic r);
    msda[pd] = b; wait_c(PH);
    scl_up();
    r = sda_ln[pd];
    mscl[pc] = 1'b0; wait_c(PH);
  endtask

  task automatic bus_start();
    msda[pd] = 1'b1; wait_c(PH);
    scl_up();
    msda[pd] = 1'b0; wait_c(PH);
    mscl[pc] = 1'b0; wait_c(PH);
  endtask

  task automatic bus_stop();
    msda[pd] = 1'b0; wait_c(PH);
    scl_up();
    msda[pd] = 1'b1; wait_c(PH);
  endtask

  task automatic send_byte(input logic [7:0] v, input int n, output logic ack);
    logic r;
    for (int i = n - 1; i >= 0; i--) bit_clk(v[i], r);
    bit_clk(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, r);
      v = {v[6:0], r};
    end
    bit_clk(mack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack, r;
    logic [7:0] v, d;
    logic [2:0] bc;
    int n, base;
    void'($urandom(32'd1234));
    wait_c(4);
    rst_n = 1'b1;
    wait_c(4);

    // R1 reset state
    chk("R1 pending", stat_pending, 1);
    chk("R1 busy", stat_busy, 0);
    chk("R1 collide", stat_collide, 0);
    chk("R1 flags", {stat_addressed, stat_gencall}, 0);
    chk("R1 pads", {scl_pad_oe, sda_pad_oe}, 0);
    chk("R1 irq", irq_cnt, 0);

    // R2 data write ignored while disabled
    wreg(2'd2, 8'hA5);
    chk("R2 write ignored", shift_q, 8'h00);

    // R4 / R6 address byte with count 3 programmed
    wreg(2'd1, 8'h5A);
    wreg(2'd0, 8'h08 | 8'h03);
    bus_start();
    chk("R3 busy after start", stat_busy, 1);
    for (int i = 7; i >= 5; i--) bit_clk(v[0] | 8'h5A >> i, r);
    chk("R4 no irq after 3 bits", irq_cnt, 0);
    for (int i = 4; i >= 0; i--) begin d = 8'h5A; bit_clk(d[i], r); end
    chk("R4 irq after 8 bits", irq_cnt, 1);
    chk("R4 address captured", shift_q, 8'h5A);
    bit_clk(1'b1, ack);
    chk("R6 ack", ack, exp_ack(8'h5A, 8'h5A, 1'b0, 1'b0));
    chk("R6 addressed", stat_addressed, 1);
    wait_c(PH);
    chk("R11 scl held", scl_pad_oe, 2'b01);
    wreg(2'd2, 8'h00);
    chk("R11 pending cleared", stat_pending, 0);
    chk("R11 scl released", scl_pad_oe, 2'b00);

    // R5 random byte lengths
    for (int it = 0; it < 8; it++) begin
      bc = (it == 0) ? 3'd0 : 3'($urandom % 8);
      d = 8'($urandom);
      n = exp_bits(bc);
      wreg(2'd0, {5'b00001, bc});
      wreg(2'd2, 8'($urandom));
      base = irq_cnt;
      for (int i = n - 1; i >= 1; i--) bit_clk(d[i], r);
      chk("R5 no early irq", irq_cnt, base);
      bit_clk(d[0], r);
      chk("R5 irq on last bit", irq_cnt, base + 1);
      chk("R5 pending set", stat_pending, 1);
      chk("R5 low bits", int'(shift_q & 8'((1 << n) - 1)), int'(d & 8'((1 << n) - 1)));
      bit_clk(1'b1, ack);
      chk("R5 data ack", ack, 0);
    end
    wreg(2'd2, 8'h00);
    bus_stop();
    chk("R3 busy after stop", stat_busy, 0);

    // R9 foreign address
    base = irq_cnt;
    bus_start();
    send_byte(8'h30, 8, ack);
    chk("R9 nack", ack, exp_ack(8'h30, 8'h5A, 1'b0, 1'b0));
    chk("R9 no irq", irq_cnt, base);
    chk("R9 not addressed", stat_addressed, 0);
    send_byte(8'h5A, 8, ack);
    chk("R9 later byte ignored", {ack, 8'(irq_cnt - base)}, {1'b1, 8'h00});
    bus_stop();

    // R8 general call
    bus_start();
    send_byte(8'h00, 8, ack);
    chk("R8 ack", ack, exp_ack(8'h00, 8'h5A, 1'b0, 1'b0));
    chk("R8 gencall flag", stat_gencall, 1);
    chk("R8 irq", irq_cnt, base + 1);
    wreg(2'd2, 8'h00);
    bus_stop();

    // R7 full-byte compare
    wreg(2'd0, 8'h28);
    wreg(2'd1, 8'h5B);
    bus_start();
    send_byte(8'h5A, 8, ack);
    chk("R7 bit0 differs nack", ack, exp_ack(8'h5A, 8'h5B, 1'b1, 1'b0));
    bus_stop();
    bus_start();
    send_byte(8'h5B, 8, ack);
    chk("R7 exact ack", ack, exp_ack(8'h5B, 8'h5B, 1'b1, 1'b0));
    chk("R7 addressed", stat_addressed, 1);
    wreg(2'd2, 8'h00);
    bus_stop();

    // R10 free data format
    wreg(2'd0, 8'h18);
    base = irq_cnt;
    bus_start();
    send_byte(8'h33, 8, ack);
    chk("R10 ack", ack, 0);
    chk("R10 data", shift_q, 8'h33);
    chk("R10 irq", irq_cnt, base + 1);
    chk("R10 not addressed", stat_addressed, 0);
    wreg(2'd2, 8'h00);
    bus_stop();

    // R12 transmit
    wreg(2'd0, 8'h08);
    wreg(2'd1, 8'h5A);
    glitch = 0;
    bus_start();
    send_byte(8'h5B, 8, ack);
    chk("R12 read address ack", ack, 0);
    wreg(2'd2, 8'hC6);
    recv_byte(1'b0, v);
    chk("R12 first byte", v, 8'hC6);
    d = 8'($urandom);
    wreg(2'd2, d);
    recv_byte(1'b1, v);
    chk("R12 random byte", v, d);
    wreg(2'd2, 8'hFF);
    bus_stop();
    chk("R12 sda steady while scl high", glitch, 0);

    // R14 collision
    bus_start();
    send_byte(8'h5B, 8, ack);
    wreg(2'd2, 8'h80);
    bit_clk(1'b0, r);
    chk("R14 collide set", stat_collide, 1);
    bit_clk(1'b1, r);
    chk("R14 released after", r, 1);
    bus_stop();

    // R13 pin routing: SCL on pair 1, SDA on pair 0
    wreg(2'd0, 8'h48);
    pc = 1; pd = 0;
    bus_start();
    send_byte(8'h5A, 8, ack);
    chk("R13 ack on sda pin 0", ack, 0);
    wait_c(PH);
    chk("R13 scl held on pin 1", scl_pad_oe, 2'b10);
    wreg(2'd2, 8'h00);
    bus_stop();
    pc = 0; pd = 1;
    bus_start();
    chk("R13 unselected start ignored", stat_busy, 0);
    bus_stop();
    pc = 0; pd = 0;

    // R2 disable in mid-frame
    wreg(2'd0, 8'h08);
    bus_start();
    send_byte(8'h5A, 8, ack);
    wait_c(PH);
    chk("R2 busy before disable", stat_busy, 1);
    wreg(2'd0, 8'h00);
    chk("R2 busy cleared", stat_busy, 0);
    chk("R2 pending forced", stat_pending, 1);
    chk("R2 collide cleared", stat_collide, 0);
    chk("R2 pads released", {scl_pad_oe, sda_pad_oe}, 0);
    wreg(2'd2, 8'h77);
    chk("R2 data unchanged", shift_q, 8'h5A);
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule